// File: doc/BRIEF.md
# Four-Lane Framed Serial Word Emitter

This block turns one parallel sample word per channel per frame into a double-data-rate serial stream on one lane per channel. It runs entirely on a fast tick clock. A frame of ticks stands for one sample period. At the last tick of every frame the block captures the four channel words. It then emits, on each lane, the word that was captured nine frames earlier, which models a fixed conversion pipeline. Alongside the lanes it produces a word-rate frame clock and a bit clock whose period covers two serial bits. Data therefore changes on both bit-clock edges.

Four configuration inputs shape the stream: serial bit order, a longer serial word for receivers that expect more bits, a fixed test pattern in place of sample data, and the bit-clock phase in steps of 60 degrees. All four are taken in once per frame, at the same tick that captures the sample words. Each frame is therefore sent entirely under one setting.

Top module: `lane_framer`

## Requirements
- R1: Lane n carries bits 8n+7..8n of `ch_data`. With `cfg_lsb_first`=0 the first eight serial bits of a frame are data bits 7,6,...,0 in that order.
- R2: The word sent in the frame that follows capture tick k+9 is the one captured at tick k. The first nine frames after reset carry all-zero words.
- R3: `sample_tick` is high in exactly the last tick of each frame, and `ch_data` is captured at the rising edge that ends that tick.
- R4: Each serial bit lasts 6 fast ticks, and a frame of W serial bits lasts exactly 6·W ticks. The next frame starts on the tick after.
- R5: `frame_clk` is high during serial bits 0 to W/2-1 and low for the rest of the frame. It rises together with bit 0.
- R6: With `cfg_lsb_first`=1 the data bits go out in the order 0,1,...,7.
- R7: `cfg_len` codes 0,1,2,3 select W = 8,10,12,14. In MSB-first order the eight data bits come first and zeros fill the rest. In LSB-first order the W-8 zeros come first, followed by data bits 0..7.
- R8: With `cfg_test`=1 every lane sends a 1 in bit slot 0 and 0 in every other slot, whatever the data, bit order or length. Sample capture and the delay line keep advancing.
- R9: `bit_clk` has a period of 12 ticks and is high for 6 of them. Its rising edge comes 1+2·c ticks after the start of an even-numbered serial bit (30°+60°·c of the bit-clock period), where c is `cfg_phase`, or `cfg_phase`-6 for codes 6 and 7. The reset code 1 gives 90°.
- R10: Changes on the configuration inputs in the middle of a frame do not alter that frame. They apply from the next frame on.
- R11: While reset is held, all lanes, `frame_clk` and `bit_clk` are 0.
- R12: Within a frame, `bit_clk` never changes in the same tick as a lane transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast tick clock, 6 ticks per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_data | input | NCH*DATA_W | Parallel sample words, channel n at bits 8n+7..8n |
| cfg_lsb_first | input | 1 | 1 sends least significant data bit first |
| cfg_len | input | 2 | Serial word length code (8/10/12/14 bits) |
| cfg_test | input | 1 | 1 replaces sample data by the fixed pattern |
| cfg_phase | input | 3 | Bit-clock phase step code |
| sample_tick | output | 1 | High in the capture tick that ends each frame |
| lane | output | NCH | Serial data lanes |
| bit_clk | output | 1 | DDR bit clock, two serial bits per period |
| frame_clk | output | 1 | Word-rate frame clock |

## Verification
The bench instantiates the block with its default parameters: four channels, 8-bit words, 6 ticks per bit and a nine-frame delay. At these settings a whole frame takes 48 to 84 ticks. This keeps the zero-filled start-up frames, the nine-frame delay and every length, order, pattern and phase code within a few thousand ticks. Six ticks per bit is the smallest tick count that places the 90° default and all six 60° steps on whole ticks, so every phase code can be checked tick by tick.

// File: rtl/lanefmt_pkg.sv
package lanefmt_pkg;

   // Extra serial slots the longest word adds beyond the data width
   localparam int EXT_MAX = 6;

   // Phase code selected at reset: 90 degrees
   localparam logic [2:0] PHASE_RESET = 3'd1;

   typedef struct packed {
      logic       lsb_first;
      logic [1:0] len;
      logic       test;
      logic [2:0] phase;
   } fmt_cfg_t;

endpackage

// File: rtl/fmt_timer.sv
module fmt_timer #(
   parameter int DATA_W    = 8,
   parameter int BIT_TICKS = 6,
   parameter int MAX_W     = DATA_W + lanefmt_pkg::EXT_MAX,
   parameter int BIDX_W    = $clog2(MAX_W),
   parameter int SUB_W     = $clog2(BIT_TICKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        len,
   output logic [SUB_W-1:0]  sub,
   output logic [BIDX_W-1:0] bidx,
   output logic              frame_last,
   output logic              frame_clk
);

   localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(BIT_TICKS - 1);
   localparam logic [BIDX_W-1:0] BASE_LAST = BIDX_W'(DATA_W - 1);
   localparam logic [BIDX_W-1:0] BASE_HALF = BIDX_W'(DATA_W / 2);

   logic [SUB_W-1:0]  sub_q;
   logic [BIDX_W-1:0] bidx_q;
   logic [BIDX_W-1:0] last_bit;
   logic [BIDX_W-1:0] half_w;

   assign last_bit   = BASE_LAST + BIDX_W'({len, 1'b0});
   assign half_w     = BASE_HALF + BIDX_W'(len);
   assign frame_last = (sub_q == SUB_LAST) && (bidx_q == last_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q  <= SUB_LAST;
         bidx_q <= BASE_LAST;
      end else if (sub_q == SUB_LAST) begin
         sub_q  <= '0;
         bidx_q <= frame_last ? '0 : bidx_q + 1'b1;
      end else begin
         sub_q  <= sub_q + 1'b1;
      end
   end

   assign sub       = sub_q;
   assign bidx      = bidx_q;
   assign frame_clk = (bidx_q < half_w);

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen #(
   parameter int BIT_TICKS = 6,
   parameter int SUB_W     = $clog2(BIT_TICKS)
) (
   input  logic [SUB_W-1:0] sub,
   input  logic             odd_bit,
   input  logic [2:0]       phase,
   output logic             bit_clk
);

   localparam int PER   = 2 * BIT_TICKS;
   localparam int HALF  = BIT_TICKS / 6;
   localparam int STEP  = BIT_TICKS / 3;
   localparam int POS_W = $clog2(2 * PER);

   logic [2:0]       code;
   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] off;
   logic [POS_W-1:0] rel;

   always_comb begin
      code = (phase >= 3'd6) ? phase - 3'd6 : phase;
      pos  = POS_W'(sub) + (odd_bit ? POS_W'(BIT_TICKS) : '0);
      off  = POS_W'(HALF) + POS_W'(code) * POS_W'(STEP);
      rel  = (pos >= off) ? pos - off : pos + POS_W'(PER) - off;
   end

   assign bit_clk = (rel < POS_W'(BIT_TICKS));

endmodule

// File: rtl/sample_delay.sv
module sample_delay #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (advance) q <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (advance) q <= g_stage[g-1].q;
         end
      end
   end

   assign dout = g_stage[DEPTH-1].q;

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
   parameter int DATA_W = 8,
   parameter int MAX_W  = DATA_W + lanefmt_pkg::EXT_MAX,
   parameter int BIDX_W = $clog2(MAX_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   input  logic              lsb_first,
   input  logic [1:0]        len,
   input  logic              test,
   input  logic [BIDX_W-1:0] bidx,
   output logic              lane
);

   localparam int EXT = MAX_W - DATA_W;

   logic [DATA_W-1:0] rev;
   logic [MAX_W-1:0]  msb_seq;
   logic [MAX_W-1:0]  lsb_seq;
   logic [MAX_W-1:0]  pat_seq;
   logic [MAX_W-1:0]  seq_d;
   logic [MAX_W-1:0]  seq_q;

   always_comb begin
      for (int i = 0; i < DATA_W; i++) rev[i] = data[DATA_W-1-i];
   end

   // Sequences are stored left-aligned in send order: slot b sits at MAX_W-1-b
   assign msb_seq = {data, {EXT{1'b0}}};
   assign lsb_seq = {rev, {EXT{1'b0}}} >> {len, 1'b0};
   assign pat_seq = {1'b1, {(MAX_W-1){1'b0}}};

   always_comb begin
      if (test)           seq_d = pat_seq;
      else if (lsb_first) seq_d = lsb_seq;
      else                seq_d = msb_seq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    seq_q <= '0;
      else if (load) seq_q <= seq_d;
   end

   assign lane = seq_q[BIDX_W'(MAX_W-1) - bidx];

endmodule

// File: rtl/lane_framer.sv
module lane_framer #(
   parameter int NCH       = 4,
   parameter int DATA_W    = 8,
   parameter int BIT_TICKS = 6,
   parameter int LATENCY   = 9
) (
   input  logic                  clk_fast,
   input  logic                  rst_n,
   input  logic [NCH*DATA_W-1:0] ch_data,
   input  logic                  cfg_lsb_first,
   input  logic [1:0]            cfg_len,
   input  logic                  cfg_test,
   input  logic [2:0]            cfg_phase,
   output logic                  sample_tick,
   output logic [NCH-1:0]        lane,
   output logic                  bit_clk,
   output logic                  frame_clk
);

   import lanefmt_pkg::*;

   localparam int MAX_W  = DATA_W + EXT_MAX;
   localparam int BIDX_W = $clog2(MAX_W);
   localparam int SUB_W  = $clog2(BIT_TICKS);
   localparam int WORD_W = NCH * DATA_W;

   if (BIT_TICKS % 6 != 0 || BIT_TICKS < 6) begin : g_bad_ticks
      $error("BIT_TICKS must be a positive multiple of 6");
   end
   if (DATA_W % 2 != 0 || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be even and at least 2");
   end
   if (NCH < 1 || LATENCY < 1) begin : g_bad_count
      $error("NCH and LATENCY must be at least 1");
   end

   fmt_cfg_t          cfg_q;
   fmt_cfg_t          cfg_in;
   logic [SUB_W-1:0]  sub;
   logic [BIDX_W-1:0] bidx;
   logic              frame_last;
   logic [WORD_W-1:0] delayed;

   assign cfg_in = '{lsb_first: cfg_lsb_first, len: cfg_len,
                     test: cfg_test, phase: cfg_phase};

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n)          cfg_q <= '{lsb_first: 1'b0, len: 2'd0, test: 1'b0, phase: PHASE_RESET};
      else if (frame_last) cfg_q <= cfg_in;
   end

   fmt_timer #(
      .DATA_W(DATA_W), .BIT_TICKS(BIT_TICKS),
      .MAX_W(MAX_W), .BIDX_W(BIDX_W), .SUB_W(SUB_W)
   ) u_timer (
      .clk(clk_fast), .rst_n(rst_n), .len(cfg_q.len),
      .sub(sub), .bidx(bidx), .frame_last(frame_last), .frame_clk(frame_clk)
   );

   bitclk_gen #(.BIT_TICKS(BIT_TICKS), .SUB_W(SUB_W)) u_bitclk (
      .sub(sub), .odd_bit(bidx[0]), .phase(cfg_q.phase), .bit_clk(bit_clk)
   );

   sample_delay #(.WIDTH(WORD_W), .DEPTH(LATENCY)) u_delay (
      .clk(clk_fast), .rst_n(rst_n), .advance(frame_last),
      .din(ch_data), .dout(delayed)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_lane
      lane_shifter #(.DATA_W(DATA_W), .MAX_W(MAX_W), .BIDX_W(BIDX_W)) u_shift (
         .clk(clk_fast), .rst_n(rst_n), .load(frame_last),
         .data(delayed[c*DATA_W +: DATA_W]),
         .lsb_first(cfg_lsb_first), .len(cfg_len), .test(cfg_test),
         .bidx(bidx), .lane(lane[c])
      );
   end

   assign sample_tick = frame_last;

endmodule

// File: rtl/lane_framer_chk.sv
module lane_framer_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sample_tick,
   input logic           frame_clk,
   input logic           bit_clk,
   input logic           cfg_test,
   input logic [NCH-1:0] lane
);

   // R5
   frame_rise_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_clk) |-> $past(sample_tick));

   // R5
   frame_high_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> frame_clk);

   // R3
   single_capture_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> !sample_tick);

   // R8
   pattern_lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && cfg_test) |=> (lane == {NCH{1'b1}}));

   // R12
   edge_off_transition_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($rose(bit_clk) || $fell(bit_clk)) && !$past(sample_tick)) |-> $stable(lane));

endmodule

bind lane_framer lane_framer_chk #(.NCH(NCH)) u_chk (
   .clk(clk_fast), .rst_n(rst_n), .sample_tick(sample_tick),
   .frame_clk(frame_clk), .bit_clk(bit_clk), .cfg_test(cfg_test), .lane(lane)
);

// File: tb/tb_lane_framer.sv
module tb_lane_framer;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;
   localparam int DW         = 8;
   localparam int TPB        = 6;
   localparam int MAXW       = 14;
   localparam int LAT        = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH*DW-1:0] ch_data = 32'h1357_9bdf;
   logic              cfg_lsb_first = 1'b0;
   logic [1:0]        cfg_len = 2'd0;
   logic              cfg_test = 1'b0;
   logic [2:0]        cfg_phase = 3'd1;
   logic              sample_tick;
   logic [NCH-1:0]    lane;
   logic              bit_clk;
   logic              frame_clk;

   int checks = 0;
   int errors = 0;

   // scoreboard of words expected on the lanes, one per frame
   logic [NCH*DW-1:0] exp_q[$];

   // configuration in effect for the current frame (bench model)
   bit       eff_lsb = 1'b0;
   int       eff_len = 0;
   bit       eff_test = 1'b0;
   int       eff_phase = 1;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_framer #(.NCH(NCH), .DATA_W(DW), .BIT_TICKS(TPB), .LATENCY(LAT)) dut (
      .clk_fast(clk), .rst_n(rst_n), .ch_data(ch_data),
      .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len), .cfg_test(cfg_test),
      .cfg_phase(cfg_phase), .sample_tick(sample_tick), .lane(lane),
      .bit_clk(bit_clk), .frame_clk(frame_clk)
   );

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   function automatic bit exp_bit(logic [DW-1:0] d, int w, bit lsb, bit tst, int b);
      if (tst)       return (b == 0);
      if (!lsb)      return (b < DW) ? d[DW-1-b] : 1'b0;
      if (b < w-DW)  return 1'b0;
      return d[b-(w-DW)];
   endfunction

   function automatic logic [31:0] next_word(logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   // driver: records each captured word and the configuration taken with it
   initial begin : driver
      for (int i = 0; i < LAT; i++) exp_q.push_back('0);
      wait (rst_n === 1'b1);
      forever begin
         @(negedge clk);
         if (sample_tick === 1'b1) begin
            exp_q.push_back(ch_data);
            eff_lsb   = cfg_lsb_first;
            eff_len   = int'(cfg_len);
            eff_test  = cfg_test;
            eff_phase = int'(cfg_phase);
            @(posedge clk);
            #1 ch_data = next_word(ch_data);
         end
      end
   end

   int  prev_sig = 1;
   bit  sig_init = 1'b0;

   task automatic watch_frame();
      logic [NCH*DW-1:0]   d;
      logic [NCH*MAXW-1:0] got;
      logic [NCH*MAXW-1:0] expv;
      int w, off, bad_fc, bad_bc, bad_st, sig;
      bit lsb, tst;
      string tag;
      if (exp_q.size() == 0) begin
         check(1'b0, "R2", "scoreboard empty", 0, 1);
         d = '0;
      end else begin
         d = exp_q.pop_front();
      end
      w    = DW + 2*eff_len;
      off  = 1 + 2*(eff_phase % 6);
      lsb  = eff_lsb;
      tst  = eff_test;
      sig  = eff_len*64 + int'(lsb)*32 + int'(tst)*16 + (eff_phase % 6);
      got  = '0; expv = '0;
      bad_fc = 0; bad_bc = 0; bad_st = 0;
      for (int t = 0; t < TPB*w; t++) begin
         if (t > 0) @(negedge clk);
         if (frame_clk !== ((t/TPB) < w/2)) bad_fc++;
         if (bit_clk !== ((((t - off) % (2*TPB) + 2*TPB) % (2*TPB)) < TPB)) bad_bc++;
         if (sample_tick !== (t == TPB*w-1)) bad_st++;
         if (t % TPB == TPB/2) begin
            for (int c = 0; c < NCH; c++) begin
               got[c*MAXW + t/TPB]  = lane[c];
               expv[c*MAXW + t/TPB] = exp_bit(d[c*DW +: DW], w, lsb, tst, t/TPB);
            end
         end
      end
      if (tst)       tag = "R8";
      else if (w > DW) tag = "R7";
      else if (lsb)  tag = "R6";
      else           tag = "R1";
      tag = {tag, " R2"};
      if (sig_init && sig != prev_sig) tag = {tag, " R10"};
      prev_sig = sig;
      sig_init = 1'b1;
      check(got == expv, tag, "lane bits", 64'(got), 64'(expv));
      check(bad_fc == 0, "R5", "frame_clk mismatched ticks", 64'(bad_fc), 0);
      check(bad_bc == 0, "R9", "bit_clk mismatched ticks", 64'(bad_bc), 0);
      check(bad_st == 0, "R3", "sample_tick mismatched ticks", 64'(bad_st), 0);
   endtask

   // monitor: locates frame starts and compares each frame to the scoreboard
   initial begin : monitor
      logic prev_fc, prev_st;
      bit   pending, start;
      wait (rst_n === 1'b1);
      prev_fc = 1'b0; prev_st = 1'b0; pending = 1'b0;
      forever begin
         @(negedge clk);
         start = (frame_clk === 1'b1) && (prev_fc === 1'b0);
         if (pending) begin
            check(start, "R4", "frame restart after 6*W ticks", 64'(start), 1);
            pending = 1'b0;
         end
         if (start) begin
            check(prev_st === 1'b1, "R3", "capture tick before frame start", 64'(prev_st), 1);
            watch_frame();
            pending = 1'b1;
         end
         prev_fc = frame_clk;
         prev_st = sample_tick;
      end
   end

   task automatic wait_frames(int n);
      repeat (n) begin
         do @(negedge clk); while (sample_tick !== 1'b1);
      end
   endtask

   // change configuration in the middle of a frame (R10)
   task automatic apply_cfg(bit lsb, logic [1:0] len, bit tst, logic [2:0] ph);
      repeat (10) @(posedge clk);
      #2;
      cfg_lsb_first = lsb;
      cfg_len       = len;
      cfg_test      = tst;
      cfg_phase     = ph;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      // R11 reset state
      check(lane === '0, "R11", "lanes in reset", 64'(lane), 0);
      check(frame_clk === 1'b0, "R11", "frame_clk in reset", 64'(frame_clk), 0);
      check(bit_clk === 1'b0, "R11", "bit_clk in reset", 64'(bit_clk), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;

      wait_frames(14);                       // R1 R2 default order, latency
      apply_cfg(1'b1, 2'd0, 1'b0, 3'd1);     // R6
      wait_frames(4);
      apply_cfg(1'b0, 2'd1, 1'b0, 3'd1);     // R7 length 10
      wait_frames(3);
      apply_cfg(1'b0, 2'd2, 1'b0, 3'd1);     // R7 length 12
      wait_frames(3);
      apply_cfg(1'b0, 2'd3, 1'b0, 3'd1);     // R7 length 14
      wait_frames(3);
      apply_cfg(1'b1, 2'd3, 1'b0, 3'd1);     // R7 LSB-first extended
      wait_frames(3);
      apply_cfg(1'b1, 2'd1, 1'b0, 3'd1);
      wait_frames(3);
      apply_cfg(1'b0, 2'd0, 1'b1, 3'd1);     // R8
      wait_frames(3);
      apply_cfg(1'b1, 2'd3, 1'b1, 3'd1);     // R8 with order and length
      wait_frames(3);
      for (int p = 0; p < 8; p++) begin      // R9 all phase codes
         apply_cfg(1'b0, 2'd0, 1'b0, 3'(p));
         wait_frames(2);
      end
      apply_cfg(1'b0, 2'd0, 1'b0, 3'd1);
      wait_frames(12);                       // R2 data flows again after pattern
      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule